// File: doc/BRIEF.md
# Burst Write Bus Master

This block is a memory-mapped bus master that moves words from a small local FIFO onto a bus in write bursts. A producer pushes data words into the FIFO through a ready/valid port. A separate command port supplies the target address, the number of beats and a byte-enable mask. Once a command is taken, the master drives the address, the beat count, the byte enables, the write strobe and the head FIFO word. It keeps presenting words until the requested number of beats has been accepted.

The bus slave throttles the master with a waitrequest input. While the slave stalls, every output of the master stays frozen. The master can also pause the burst on its own by lowering the write strobe whenever its FIFO is empty. It resumes with the next stored word as soon as data arrives. A beat is counted only on an edge where the strobe is high and waitrequest is low. One cycle after the final beat is accepted, the master raises a single-cycle completion pulse and returns to idle, ready for the next command.

Top module: `burst_wr_master`

## Requirements
- R1: While reset is asserted and directly after it, `bus_write` and `done` are low and `cmd_ready` and `in_ready` are high.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the master is idle. A command offered while a burst runs has no effect on the address, beat count or byte enables of that burst. `cmd_len` must be non-zero.
- R3: Every beat of a burst carries the commanded address (the address is not incremented), `bus_burstcount` equal to the commanded length, and the commanded byte-enable mask. The first beat presents these together with the first FIFO word.
- R4: After any edge where `bus_write` and `bus_waitrequest` are both high, `bus_write` stays high and `bus_address`, `bus_burstcount`, `bus_byteenable` and `bus_writedata` keep their values.
- R5: A beat is accepted on a rising edge where `bus_write` is high and `bus_waitrequest` is low. A burst ends after exactly `cmd_len` accepted beats.
- R6: During a burst, `bus_write` is high exactly when the local FIFO holds at least one word. After a pause for an empty FIFO, the burst resumes with the next stored word.
- R7: In the cycle after the final beat is accepted, `bus_write` is low and `done` is high. `done` is high for that one cycle only.
- R8: Words leave on the bus in the order they were pushed into the FIFO, each exactly once.
- R9: A word is stored on an edge where `in_valid` and `in_ready` are high. `in_ready` is low when the FIFO holds DEPTH words, and a push offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_addr | input | AW | Burst target address |
| cmd_len | input | BCW | Beats in the burst, 1..MAX_BURST |
| cmd_be | input | DW/8 | Byte-enable mask for all beats |
| in_valid | input | 1 | Data word offered to FIFO |
| in_ready | output | 1 | FIFO has room |
| in_data | input | DW | Data word |
| bus_address | output | AW | Bus address |
| bus_burstcount | output | BCW | Bus beat count |
| bus_byteenable | output | DW/8 | Bus byte enables |
| bus_write | output | 1 | Bus write strobe |
| bus_writedata | output | DW | Bus write data |
| bus_waitrequest | input | 1 | Slave stall |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
The bench builds the master with a four-word FIFO and bursts of up to eight beats. Because a burst can be twice as long as the FIFO, the producer has to refill the FIFO while the burst is running. With a random producer, both the empty-FIFO pause and the full-FIFO push refusal occur often. The narrow bursts also let directed cases reach a one-beat burst, a burst drained entirely from a pre-filled FIFO, and a long run of slave stalls within a few dozen cycles.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bwm_state_e;

  // Count width able to hold the value n.
  function automatic int bwm_cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bwm_data_fifo.sv
module bwm_data_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = bwm_pkg::bwm_cnt_w(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    push_ready = (cnt_q != FULL_CNT);
    empty      = (cnt_q == '0);
    push_ok    = push && push_ready;
    pop_ok     = pop && !empty;
    head       = slot_q[rd_q];
  end

  always_comb begin
    wr_d  = push_ok ? ptr_next(wr_q) : wr_q;
    rd_d  = pop_ok  ? ptr_next(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // One storage register per slot, each with its own write enable.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push_ok && (wr_q == PW'(i));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        slot_q[i] <= push_data;
      end
    end
  end

  p_pop_only_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop) |=> $stable(cnt_q));

  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(head));

endmodule

// File: rtl/bwm_burst_seq.sv
module bwm_burst_seq
  import bwm_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BEW = 4,
  parameter int BCW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [BCW-1:0] cmd_len,
  input  logic [BEW-1:0] cmd_be,
  input  logic           fifo_empty,
  output logic           fifo_pop,
  input  logic           waitreq,
  output logic           write_o,
  output logic [AW-1:0]  addr_o,
  output logic [BCW-1:0] len_o,
  output logic [BEW-1:0] be_o,
  output logic           done_o
);
  bwm_state_e     state_q, state_d;
  logic [BCW-1:0] rem_q, rem_d;
  logic [AW-1:0]  addr_q;
  logic [BCW-1:0] len_q;
  logic [BEW-1:0] be_q;
  logic           done_q, done_d;
  logic           running, load_cmd, accept, last_beat;

  always_comb begin
    running   = (state_q == ST_RUN);
    cmd_ready = !running;
    load_cmd  = cmd_valid && !running;
    write_o   = running && !fifo_empty;
    accept    = write_o && !waitreq;
    last_beat = (rem_q == BCW'(1));
    fifo_pop  = accept;
    addr_o    = addr_q;
    len_o     = len_q;
    be_o      = be_q;
    done_o    = done_q;
  end

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    if (load_cmd) begin
      state_d = ST_RUN;
      rem_d   = cmd_len;
    end else if (accept) begin
      rem_d = rem_q - 1'b1;
      if (last_beat) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  // Command fields, enabled only on command load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      be_q   <= '0;
    end else if (load_cmd) begin
      addr_q <= cmd_addr;
      len_q  <= cmd_len;
      be_q   <= cmd_be;
    end
  end

  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (cmd_len != '0));

  p_busy_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmd_valid) |=> ($stable(addr_o) && $stable(len_o) && $stable(be_o)));

  p_hold_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (write_o && waitreq) |=>
      (write_o && $stable(addr_o) && $stable(len_o) && $stable(be_o)));

  p_end_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_beat) |=> (done_o && !write_o && cmd_ready));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_rem_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (rem_q != '0 && rem_q <= len_o));

endmodule

// File: rtl/burst_wr_master.sv
module burst_wr_master #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int DEPTH     = 8,
  parameter int MAX_BURST = 16,
  localparam int BEW      = DW / 8,
  localparam int BCW      = bwm_pkg::bwm_cnt_w(MAX_BURST)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [BCW-1:0] cmd_len,
  input  logic [BEW-1:0] cmd_be,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic [AW-1:0]  bus_address,
  output logic [BCW-1:0] bus_burstcount,
  output logic [BEW-1:0] bus_byteenable,
  output logic           bus_write,
  output logic [DW-1:0]  bus_writedata,
  input  logic           bus_waitrequest,
  output logic           done
);
  logic rst_meta_q, rst_sync_q;
  logic fifo_empty, fifo_pop;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bwm_data_fifo #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .push       (in_valid),
    .push_data  (in_data),
    .push_ready (in_ready),
    .pop        (fifo_pop),
    .head       (bus_writedata),
    .empty      (fifo_empty)
  );

  bwm_burst_seq #(
    .AW  (AW),
    .BEW (BEW),
    .BCW (BCW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .cmd_be     (cmd_be),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .waitreq    (bus_waitrequest),
    .write_o    (bus_write),
    .addr_o     (bus_address),
    .len_o      (bus_burstcount),
    .be_o       (bus_byteenable),
    .done_o     (done)
  );

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (bus_write && bus_waitrequest) |=> (bus_write && $stable(bus_writedata)));

  p_write_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    bus_write |-> !fifo_empty);

endmodule

// File: tb/burst_wr_master_bench.sv
module burst_wr_master_bench;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 4;
  localparam int MAXB  = 8;
  localparam int BEW   = DW / 8;
  localparam int BCW   = $clog2(MAXB + 1);

  logic           clk;
  logic           rst_n;
  logic           cmd_valid;
  logic           cmd_ready;
  logic [AW-1:0]  cmd_addr;
  logic [BCW-1:0] cmd_len;
  logic [BEW-1:0] cmd_be;
  logic           in_valid;
  logic           in_ready;
  logic [DW-1:0]  in_data;
  logic [AW-1:0]  bus_address;
  logic [BCW-1:0] bus_burstcount;
  logic [BEW-1:0] bus_byteenable;
  logic           bus_write;
  logic [DW-1:0]  bus_writedata;
  logic           bus_waitrequest;
  logic           done;

  burst_wr_master #(
    .AW        (AW),
    .DW        (DW),
    .DEPTH     (DEPTH),
    .MAX_BURST (MAXB)
  ) u_burst_wr_master (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_addr        (cmd_addr),
    .cmd_len         (cmd_len),
    .cmd_be          (cmd_be),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_data         (in_data),
    .bus_address     (bus_address),
    .bus_burstcount  (bus_burstcount),
    .bus_byteenable  (bus_byteenable),
    .bus_write       (bus_write),
    .bus_writedata   (bus_writedata),
    .bus_waitrequest (bus_waitrequest),
    .done            (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model state
  logic [DW-1:0]  exp_q [1024];
  int             wr_i = 0, rd_i = 0, level = 0;
  bit             busy = 0, done_due = 0, prev_stall = 0;
  int             rem = 0;
  logic [AW-1:0]  m_addr;
  logic [BCW-1:0] m_len;
  logic [BEW-1:0] m_be;
  logic [AW-1:0]  p_addr;
  logic [BCW-1:0] p_len;
  logic [BEW-1:0] p_be;
  logic [DW-1:0]  p_data;
  logic [DW-1:0]  next_val = 32'h1000_0000;

  // Stimulus controls
  int             push_mode = 0;   // 0 off, 1 always, 2 random
  int             wait_mode = 0;   // 0 never, 1 random, 2 always
  bit             marker_req = 0;
  bit             busy_poke = 0;
  bit             cmd_req = 0;
  logic [AW-1:0]  c_addr;
  logic [BCW-1:0] c_len;
  logic [BEW-1:0] c_be;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit want_wait();
    case (wait_mode)
      0:       return 1'b0;
      2:       return 1'b1;
      default: return ($urandom_range(0, 99) < 40);
    endcase
  endfunction

  function automatic bit want_push();
    case (push_mode)
      0:       return 1'b0;
      1:       return 1'b1;
      default: return ($urandom_range(0, 99) < 55);
    endcase
  endfunction

  task automatic tick();
    bit acc, pok, hs, exp_done;
    @(negedge clk);
    exp_done = done_due;
    done_due = 0;
    // R7: completion pulse timing
    chk(done == exp_done, "R7 done", done, exp_done);
    if (exp_done) chk(!bus_write, "R7 write low after last beat", bus_write, 0);
    // R4: frozen outputs after a stall
    if (prev_stall) begin
      chk(bus_write, "R4 write held", bus_write, 1);
      chk(bus_address == p_addr, "R4 address held", bus_address, p_addr);
      chk(bus_burstcount == p_len, "R4 burstcount held", bus_burstcount, p_len);
      chk(bus_byteenable == p_be, "R4 byteenable held", bus_byteenable, p_be);
      chk(bus_writedata == p_data, "R4 writedata held", bus_writedata, p_data);
    end
    // R6: strobe follows FIFO occupancy inside a burst
    if (busy) chk(bus_write == (level > 0), "R6 write vs fifo level", bus_write, level > 0);
    else      chk(!bus_write, "R5 no write outside burst", bus_write, 0);
    chk(cmd_ready == !busy, "R2 cmd_ready only when idle", cmd_ready, !busy);
    chk(in_ready == (level < DEPTH), "R9 in_ready vs level", in_ready, level < DEPTH);
    // R3: command fields on every beat
    if (bus_write) begin
      chk(bus_address == m_addr, "R3 address", bus_address, m_addr);
      chk(bus_burstcount == m_len, "R3 burstcount", bus_burstcount, m_len);
      chk(bus_byteenable == m_be, "R3 byteenable", bus_byteenable, m_be);
    end

    // Drive inputs for the coming edge
    bus_waitrequest = want_wait();
    if (marker_req) begin
      in_valid = 1'b1;
      in_data  = 32'hDEAD_BEEF;
    end else begin
      in_valid = want_push();
      in_data  = next_val;
    end
    if (cmd_req) begin
      cmd_valid = 1'b1;
      cmd_addr  = c_addr;
      cmd_len   = c_len;
      cmd_be    = c_be;
    end else if (busy_poke && busy) begin
      cmd_valid = 1'b1;
      cmd_addr  = AW'($urandom);
      cmd_len   = BCW'(1);
      cmd_be    = BEW'($urandom);
    end else begin
      cmd_valid = 1'b0;
    end

    acc = bus_write && !bus_waitrequest;
    pok = in_valid && in_ready;
    hs  = cmd_valid && cmd_ready && cmd_req;

    if (acc) begin
      chk(bus_writedata == exp_q[rd_i], "R8 data order", bus_writedata, exp_q[rd_i]);
      rd_i++;
      rem--;
      level--;
      if (rem == 0) begin
        busy = 0;
        done_due = 1;
      end
    end
    if (pok) begin
      if (marker_req) begin
        chk(1'b0, "R9 push accepted while full", 1, 0);
      end else begin
        exp_q[wr_i] = in_data;
        wr_i++;
        next_val = next_val + 32'd3;
      end
      level++;
    end
    if (hs) begin
      busy    = 1;
      rem     = int'(c_len);
      m_addr  = c_addr;
      m_len   = c_len;
      m_be    = c_be;
      cmd_req = 0;
    end
    prev_stall = bus_write && bus_waitrequest;
    p_addr = bus_address;
    p_len  = bus_burstcount;
    p_be   = bus_byteenable;
    p_data = bus_writedata;
  endtask

  task automatic issue(input logic [AW-1:0] a, input int len, input logic [BEW-1:0] be);
    c_addr  = a;
    c_len   = BCW'(len);
    c_be    = be;
    cmd_req = 1;
    while (cmd_req) tick();
  endtask

  task automatic run_to_done();
    while (busy) tick();
    tick();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    void'($urandom(32'd20240517));
    cmd_valid = 0; cmd_addr = '0; cmd_len = '0; cmd_be = '0;
    in_valid = 0; in_data = '0; bus_waitrequest = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_write, "R1 write low in reset", bus_write, 0);
    chk(!done, "R1 done low in reset", done, 0);
    chk(cmd_ready, "R1 cmd_ready in reset", cmd_ready, 1);
    chk(in_ready, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!bus_write && !done && cmd_ready && in_ready, "R1 idle after reset",
        {bus_write, done, cmd_ready, in_ready}, 4'b0011);

    // Directed: fill FIFO, offer a push while full (R9), then drain with no stalls.
    push_mode = 1; wait_mode = 0;
    while (level < DEPTH) tick();
    push_mode = 0;
    marker_req = 1; tick(); marker_req = 0;
    issue(16'h0100, DEPTH, 4'hF);
    run_to_done();

    // Directed: one-beat burst (R5, R7) with random stalls.
    push_mode = 1; wait_mode = 1;
    issue(16'h0200, 1, 4'h3);
    run_to_done();

    // Directed: starved burst (R6) with commands poked while busy (R2).
    push_mode = 0; wait_mode = 0; busy_poke = 1;
    issue(16'h0300, MAXB, 4'hC);
    repeat (6) tick();
    push_mode = 2;
    run_to_done();
    busy_poke = 0;

    // Directed: long stall run mid-burst (R4).
    push_mode = 1; wait_mode = 0;
    issue(16'h0400, MAXB, 4'h5);
    repeat (2) tick();
    wait_mode = 2;
    repeat (7) tick();
    wait_mode = 1;
    run_to_done();

    // Random bursts
    for (int n = 0; n < 60; n++) begin
      push_mode = ($urandom_range(0, 3) == 0) ? 1 : 2;
      wait_mode = $urandom_range(0, 1);
      busy_poke = ($urandom_range(0, 3) == 0);
      issue(AW'($urandom), $urandom_range(1, MAXB), BEW'($urandom));
      run_to_done();
      repeat ($urandom_range(0, 3)) tick();
    end
    busy_poke = 0;
    chk(rd_i <= wr_i, "R8 no extra words", rd_i, wr_i);
    report();
  end

endmodule